// File: doc/BRIEF.md
# Dual-Strobe Burst Address Generator

This block produces the word address that a synchronous memory array uses for single accesses and for four-beat bursts. On a rising clock edge it captures an external address when either of two active-low load strobes is asserted. These are a processor strobe and a controller strobe. On later edges an active-low advance input steps a 2-bit beat counter. The two low bits of the output address then follow the chosen burst order, and the upper bits stay as they were loaded.

The order is chosen by an input that is sampled together with the strobe, so each burst keeps the order it started with. Linear order adds the beat count to the loaded low bits, modulo 4. Interleaved order XORs the loaded low bits with the beat count.

Chip-enable qualification follows the usual split. A strobe loads only while the chip enable is asserted. A controller strobe seen with the chip disabled ends the running burst. A processor strobe seen with the chip disabled is ignored. A fresh address may be loaded on every edge, so bursts are optional.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous active-high reset drives `mem_addr` to 0 and leaves no burst running, so advance pulses before the first load leave `mem_addr` at 0.
- R2: When `proc_strb_n` is 0 and `chip_en_n` is 0 at a rising edge, `mem_addr` equals the sampled `ext_addr` after that edge.
- R3: When `ctrl_strb_n` is 0 and `chip_en_n` is 0 at a rising edge, `mem_addr` equals the sampled `ext_addr` after that edge, whatever `proc_strb_n` is.
- R4: A processor strobe sampled while `chip_en_n` is 1, with `ctrl_strb_n` and `adv_n` both 1, leaves `mem_addr` unchanged.
- R5: A controller strobe sampled while `chip_en_n` is 1 ends the running burst without changing `mem_addr`; later advance pulses have no effect until the next load.
- R6: With `order_sel` = 0 at load (linear), beat n has low bits (L + n) mod 4, where L is the loaded low two bits.
- R7: With `order_sel` = 1 at load (interleaved), beat n has low bits L XOR n.
- R8: `order_sel` takes effect only on a load edge; changing it during a burst does not change the sequence.
- R9: Advancing never changes `mem_addr` bits above bit 1; after four advances the address is back at the loaded value.
- R10: With no strobe asserted and `adv_n` = 1, `mem_addr` holds its value.
- R11: Loads on consecutive edges each take effect on the next edge, with no idle cycle between them.
- R12: A qualified load in the same cycle as `adv_n` = 0 takes precedence and restarts the burst at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External address, captured on a qualified load |
| proc_strb_n | input | 1 | Processor load strobe, active low, gated by chip enable |
| ctrl_strb_n | input | 1 | Controller load strobe, active low; ends the burst when the chip is disabled |
| adv_n | input | 1 | Burst advance, active low |
| chip_en_n | input | 1 | Chip enable, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved, sampled at load |
| mem_addr | output | ADDR_W | Internal array address, registered |

## Verification
The hardest situation to reach is a mix of cases in one run: strobes arriving with the chip disabled, order changes in the middle of a burst, and a load landing in the same cycle as an advance. These matter most when each happens after a partially completed burst, with the counter at a nonzero beat. The bench first drives directed sequences that leave the counter at beats 1 to 3 before such an event. It then runs a long random phase that weights the advance input low, so that bursts reach deep beats and wrap before the next strobe or deselect. A behavioural model is compared against `mem_addr` on every cycle.

// File: rtl/bag_pkg.sv
package bag_pkg;
    localparam int BURST_BITS = 2;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef logic [BURST_BITS-1:0] beat_t;

    typedef struct packed {
        logic load;
        logic desel;
        logic step;
    } ctl_s;

    function automatic beat_t map_beat(beat_t start, beat_t n, order_e ord);
        beat_t r;
        if (ord == ORD_INTERLEAVE) r = start ^ n;
        else                       r = beat_t'(start + n);
        return r;
    endfunction
endpackage

// File: rtl/bag_burst_ctl.sv
module bag_burst_ctl
    import bag_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_s  ctl,
    output beat_t beat,
    output logic  active
);
    always_ff @(posedge clk) begin
        if (rst) begin
            beat   <= '0;
            active <= 1'b0;
        end else if (ctl.load) begin
            beat   <= '0;
            active <= 1'b1;
        end else if (ctl.desel) begin
            active <= 1'b0;
        end else if (ctl.step && active) begin
            beat <= beat + beat_t'(1);
        end
    end

    // R10: no load and no step leaves the beat alone
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.step) |=> $stable(beat));

    // R5: without a running burst only a load moves the beat
    p_inactive_r5: assert property (@(posedge clk) disable iff (rst)
        (!active && !ctl.load) |=> $stable(beat));

    // R6: a step inside a burst moves exactly one beat
    p_step_r6: assert property (@(posedge clk) disable iff (rst)
        (active && ctl.step && !ctl.load && !ctl.desel) |=> beat == beat_t'($past(beat) + 1'b1));

    // R12: a load restarts at beat 0 even with a step
    p_load_first_r12: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (beat == '0 && active));
endmodule

// File: rtl/bag_order_map.sv
module bag_order_map
    import bag_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] base,
    input  beat_t             beat,
    input  order_e            ord,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - BURST_BITS;

    generate
        if (HI_W > 0) begin : g_hi
            assign addr[ADDR_W-1:BURST_BITS] = base[ADDR_W-1:BURST_BITS];
        end
    endgenerate

    assign addr[BURST_BITS-1:0] = map_beat(base[BURST_BITS-1:0], beat, ord);

    initial begin
        p_width_ok_r9: assert (ADDR_W > BURST_BITS);
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic              chip_en_n,
    input  logic              order_sel,
    output logic [ADDR_W-1:0] mem_addr
);
    localparam int HI_LSB = BURST_BITS;

    ctl_s              ctl;
    logic [ADDR_W-1:0] base_q;
    order_e            ord_q;
    beat_t             beat;
    logic              active;

    always_comb begin
        ctl.load  = !chip_en_n && (!proc_strb_n || !ctrl_strb_n);
        ctl.desel = chip_en_n && !ctrl_strb_n;
        ctl.step  = !adv_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ord_q  <= ORD_LINEAR;
        end else if (ctl.load) begin
            base_q <= ext_addr;
            ord_q  <= order_e'(order_sel);
        end
    end

    bag_burst_ctl u_ctl (
        .clk    (clk),
        .rst    (rst),
        .ctl    (ctl),
        .beat   (beat),
        .active (active)
    );

    bag_order_map #(.ADDR_W(ADDR_W)) u_map (
        .base (base_q),
        .beat (beat),
        .ord  (ord_q),
        .addr (mem_addr)
    );

    // R1: reset leaves address zero
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> mem_addr == '0);

    // R2: processor strobe with chip enabled loads
    p_proc_load_r2: assert property (@(posedge clk) disable iff (rst)
        (!proc_strb_n && !chip_en_n) |=> mem_addr == $past(ext_addr));

    // R3: controller strobe with chip enabled loads
    p_ctrl_load_r3: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_strb_n && !chip_en_n) |=> mem_addr == $past(ext_addr));

    // R4: processor strobe with chip disabled is ignored
    p_ignore_r4: assert property (@(posedge clk) disable iff (rst)
        (!proc_strb_n && chip_en_n && ctrl_strb_n && adv_n) |=> $stable(mem_addr));

    // R9: upper bits move only on a load
    p_upper_r9: assert property (@(posedge clk) disable iff (rst)
        !ctl.load |=> $stable(mem_addr[ADDR_W-1:HI_LSB]));
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          proc_strb_n = 1'b1;
    logic          ctrl_strb_n = 1'b1;
    logic          adv_n = 1'b1;
    logic          chip_en_n = 1'b0;
    logic          order_sel = 1'b0;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int failures = 0;

    logic [AW-1:0] m_base = '0;
    int            m_cnt = 0;
    bit            m_act = 0;
    bit            m_il = 0;

    always #4 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_burst_addr_gen (
        .clk(clk), .rst(rst), .ext_addr(ext_addr), .proc_strb_n(proc_strb_n),
        .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n), .chip_en_n(chip_en_n),
        .order_sel(order_sel), .mem_addr(mem_addr)
    );

    function automatic logic [AW-1:0] expect_addr();
        int lo;
        int b;
        b = int'(m_base[1:0]);
        lo = m_il ? (b ^ m_cnt) : ((b + m_cnt) % 4);
        return {m_base[AW-1:2], 2'(lo)};
    endfunction

    task automatic check(input string tag, input logic [AW-1:0] exp);
        checks++;
        if (mem_addr !== exp) begin
            failures++;
            $display("FAIL %s: mem_addr=%h expected=%h", tag, mem_addr, exp);
        end
    endtask

    // one clock: apply inputs, update the model at the edge, compare at the falling edge
    task automatic cyc(input string tag, input logic [AW-1:0] a, input bit ps, input bit cs,
                       input bit adv, input bit ce, input bit ord);
        ext_addr = a; proc_strb_n = ps; ctrl_strb_n = cs; adv_n = adv;
        chip_en_n = ce; order_sel = ord;
        @(posedge clk);
        if (rst) begin
            m_base = '0; m_cnt = 0; m_act = 0; m_il = 0;
        end else if (!ce && (!ps || !cs)) begin
            m_base = a; m_cnt = 0; m_act = 1; m_il = ord;
        end else if (ce && !cs) begin
            m_act = 0;
        end else if (!adv && m_act) begin
            m_cnt = (m_cnt + 1) % 4;
        end
        @(negedge clk);
        check(tag, expect_addr());
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [AW-1:0] snap;
        cyc("R1 reset", 20'hABCDE, 1, 1, 1, 0, 0);
        cyc("R1 reset", 20'hABCDE, 1, 1, 1, 0, 0);
        check("R1 reset value", '0);
        rst = 1'b0;
        cyc("R1 adv before load", 20'hABCDE, 1, 1, 0, 0, 0);
        check("R1 adv before load", '0);

        // linear burst from low bits 01
        cyc("R2 proc load", 20'h12345, 0, 1, 1, 0, 0);
        check("R2 proc load", 20'h12345);
        for (int i = 1; i <= 4; i++) begin
            cyc("R6 linear", 20'h0, 1, 1, 0, 0, 0);
            check("R6 R9 linear", {18'(20'h12345 >> 2), 2'((1 + i) % 4)});
        end
        check("R9 wrap", 20'h12345);

        // interleaved burst from low bits 10, order flips mid-burst
        cyc("R3 ctrl load", 20'h0FFF6, 0, 0, 1, 0, 1);
        check("R3 ctrl load", 20'h0FFF6);
        cyc("R7 interleave", 20'h0, 1, 1, 0, 0, 1);
        check("R7 beat1", 20'h0FFF7);
        cyc("R8 order change", 20'h0, 1, 1, 0, 0, 0);
        check("R8 beat2 kept interleave", 20'h0FFF4);
        cyc("R7 interleave", 20'h0, 1, 1, 0, 0, 0);
        check("R7 beat3", 20'h0FFF5);

        // hold
        for (int i = 0; i < 3; i++) cyc("R10 hold", 20'h55555, 1, 1, 1, 0, 1);
        check("R10 hold", 20'h0FFF5);

        // processor strobe with chip disabled
        cyc("R4 ignored", 20'h33333, 0, 1, 1, 1, 0);
        check("R4 ignored", 20'h0FFF5);

        // controller strobe with chip disabled ends burst
        cyc("R5 deselect", 20'h44444, 1, 0, 1, 1, 0);
        check("R5 deselect", 20'h0FFF5);
        cyc("R5 adv after deselect", 20'h0, 1, 1, 0, 0, 0);
        cyc("R5 adv after deselect", 20'h0, 1, 1, 0, 0, 0);
        check("R5 no advance", 20'h0FFF5);

        // back-to-back loads
        cyc("R11 b2b", 20'h11111, 0, 1, 1, 0, 0);
        check("R11 first", 20'h11111);
        cyc("R11 b2b", 20'h22222, 1, 0, 1, 0, 0);
        check("R11 second", 20'h22222);
        cyc("R11 b2b", 20'h33333, 0, 0, 1, 0, 1);
        check("R11 third", 20'h33333);

        // load with advance in same cycle after partial burst
        cyc("R12 setup", 20'h0, 1, 1, 0, 0, 0);
        check("R12 setup beat1 interleave", 20'h33332);
        cyc("R12 load+adv", 20'h7777B, 0, 1, 0, 0, 0);
        check("R12 restart beat0", 20'h7777B);
        cyc("R12 next", 20'h0, 1, 1, 0, 0, 0);
        check("R6 R12 next linear", 20'h77778);

        // random mix, advance weighted low
        for (int i = 0; i < 2000; i++) begin
            snap = AW'($urandom);
            cyc("mix R2 R3 R4 R5 R6 R7 R8 R9 R10",
                snap, ($urandom % 6) != 0, ($urandom % 8) != 0,
                ($urandom % 4) == 0, ($urandom % 5) == 0, $urandom % 2);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule